// File: doc/BRIEF.md
# Message Send Command Engine

This block turns a four-word send command from a processor into a complete message on an on-chip network port. The processor writes the words in a fixed order on a single write strobe: destination rank, payload buffer address, payload length in 32-bit words, and message tag. After the fourth word the engine takes over. It emits a two-word header and fetches the payload straight from memory through a generic read-request/read-data port. It then streams the payload behind the header onto a valid/ready output. The processor does not handle any payload data.

Memory reads are pipelined. Up to `DEPTH` reads can be in flight, and the engine only issues one when the on-chip payload buffer has a slot for every read not yet forwarded. Back-pressure from the network therefore never loses data. Status is given as a busy level, a one-cycle completion pulse and a sticky error flag for command writes that arrive while a send is running.

Top module: `msg_send_engine`

## Requirements
- R1: Command words are taken in the order destination, address, length, tag. The first network word is {destination[15:0], tag[15:0]}, with the destination in bits 31:16.
- R2: The second network word is the 32-bit payload length in words.
- R3: Payload word k is the memory word read at address base + 4*k, and payload words are sent in increasing k after the two header words.
- R4: A length of zero sends only the two header words and issues no memory read.
- R5: No more than DEPTH (4) memory reads are outstanding at any time. A request is withheld while in-flight reads plus buffered words equal DEPTH.
- R6: A command write while busy is ignored and does not disturb the next command. It sets the error flag, which stays set until reset.
- R7: done is high for exactly one cycle, in the cycle after the last message word is accepted. busy is already low in that cycle.
- R8: Out of reset, busy, done, the error flag, net_valid and mem_req are low. busy is high in the cycle after the fourth command word.
- R9: While net_valid is high and net_ready is low, net_valid stays high and net_data stays unchanged.
- R10: Exactly length memory reads are accepted per send, and mem_req is only asserted while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| busy | output | 1 | A send is in progress |
| done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Sticky flag: command written while busy |
| mem_req | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address of the read |
| mem_rvalid | input | 1 | Read data valid (in request order) |
| mem_rdata | input | 32 | Read data |
| net_valid | output | 1 | Network word valid |
| net_ready | input | 1 | Network accepts the word |
| net_data | output | 32 | Network word |

## Verification
The hardest case to reach is the read credit limit. The payload buffer has to be full with reads still in flight, and at the same moment the engine must hold back its next request. The bench gets there with directed sends in which the network refuses words for many cycles while memory accepts and returns every read at once. It also runs random sends where memory latency and network stalls vary per message. Throughout, the bench compares its own count of unanswered reads with the limit.

// File: rtl/msg_send_engine.sv
module msg_send_engine #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          done,
  output logic          cmd_err,
  output logic          mem_req,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          net_valid,
  input  logic          net_ready,
  output logic [DW-1:0] net_data
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR0, S_HDR1, S_PAY} state_t;

  state_t          state;
  logic [1:0]      widx;
  logic [DW-1:0]   dest_q, size_q, tag_q;
  logic [AW-1:0]   base_q;
  logic [DW-1:0]   issued, sent;
  logic [CNTW-1:0] inflight, fcnt;
  logic [PW-1:0]   wptr, rptr;
  logic [DW-1:0]   buf_q [DEPTH];
  logic            done_q, err_q;

  logic            room, req_fire, fire, pop, last;
  logic [CNTW:0]   used;

  assign busy    = (state != S_IDLE);
  assign done    = done_q;
  assign cmd_err = err_q;

  assign used     = {1'b0, inflight} + {1'b0, fcnt};
  assign room     = used < (CNTW+1)'(DEPTH);
  assign mem_req  = busy && (issued != size_q) && room;
  assign mem_addr = base_q + AW'(issued * 4);
  assign req_fire = mem_req && mem_req_ready;

  always_comb begin
    net_valid = 1'b0;
    net_data  = '0;
    case (state)
      S_HDR0: begin net_valid = 1'b1; net_data = {dest_q[15:0], tag_q[15:0]}; end
      S_HDR1: begin net_valid = 1'b1; net_data = size_q; end
      S_PAY:  begin net_valid = (fcnt != '0); net_data = buf_q[rptr]; end
      default: ;
    endcase
  end

  assign fire = net_valid && net_ready;
  assign pop  = fire && (state == S_PAY);
  assign last = fire && (((state == S_HDR1) && (size_q == '0)) ||
                         ((state == S_PAY) && (sent == size_q - 1'b1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      widx     <= '0;
      dest_q   <= '0;
      base_q   <= '0;
      size_q   <= '0;
      tag_q    <= '0;
      issued   <= '0;
      sent     <= '0;
      inflight <= '0;
      fcnt     <= '0;
      wptr     <= '0;
      rptr     <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (cmd_wr && busy) err_q <= 1'b1;

      if (cmd_wr && !busy) begin
        widx <= widx + 2'd1;
        case (widx)
          2'd0: dest_q <= cmd_data;
          2'd1: base_q <= AW'(cmd_data);
          2'd2: size_q <= cmd_data;
          default: begin
            tag_q  <= cmd_data;
            state  <= S_HDR0;
            issued <= '0;
            sent   <= '0;
          end
        endcase
      end

      if (req_fire) issued <= issued + 1'b1;
      inflight <= inflight + CNTW'(req_fire) - CNTW'(mem_rvalid);
      fcnt     <= fcnt + CNTW'(mem_rvalid) - CNTW'(pop);

      if (mem_rvalid) begin
        buf_q[wptr] <= mem_rdata;
        wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      end
      if (pop) begin
        rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
        sent <= sent + 1'b1;
      end

      if (fire) begin
        case (state)
          S_HDR0: state <= S_HDR1;
          S_HDR1: state <= (size_q == '0) ? S_IDLE : S_PAY;
          S_PAY:  if (last) state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/msg_send_checker.sv
module msg_send_checker #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic          busy,
  input logic          done,
  input logic          cmd_err,
  input logic          mem_req,
  input logic          mem_req_ready,
  input logic          mem_rvalid,
  input logic          net_valid,
  input logic          net_ready,
  input logic [DW-1:0] net_data
);
  logic [7:0] lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl <= '0;
    else        lvl <= lvl + 8'(mem_req && mem_req_ready) - 8'(mem_rvalid);
  end

  a_r5_inflight_cap: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= 8'(DEPTH));
  a_r5_no_req_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == 8'(DEPTH)) |-> !mem_req);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (net_valid && !net_ready) |=> (net_valid && $stable(net_data)));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> cmd_err);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!net_valid && !mem_req));
endmodule

bind msg_send_engine msg_send_checker #(.DW(DW), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy), .done(done),
  .cmd_err(cmd_err), .mem_req(mem_req), .mem_req_ready(mem_req_ready),
  .mem_rvalid(mem_rvalid), .net_valid(net_valid), .net_ready(net_ready),
  .net_data(net_data)
);

// File: tb/test_msg_send_engine.sv
module test_msg_send_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        busy, done, cmd_err, mem_req, net_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr, net_data;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        net_ready = 1'b0;

  msg_send_engine #(.DEPTH(DEPTH)) i_msg_send_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .busy(busy), .done(done), .cmd_err(cmd_err),
    .mem_req(mem_req), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .net_valid(net_valid), .net_ready(net_ready), .net_data(net_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int net_pct = 100, mem_pct = 100, rv_pct = 100;
  int done_cnt = 0, done_busy_bad = 0, done_wide = 0;
  int hold_bad = 0, cap_bad = 0, rd_cnt = 0;
  logic done_prev = 1'b0;
  logic hold_pend = 1'b0;
  logic [31:0] hold_d = '0;
  logic [31:0] pend[$];
  logic [31:0] rxq[$];

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] + 16'h0101};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0;
      mem_rvalid    = 1'b0;
      net_ready     = 1'b0;
    end else begin
      if (done) begin
        done_cnt++;
        if (busy) done_busy_bad++;
        if (done_prev) done_wide++;
      end
      done_prev = done;
      if (hold_pend && (!net_valid || net_data != hold_d)) hold_bad++;
      net_ready = ($urandom_range(99) < net_pct);
      if (net_valid && net_ready) rxq.push_back(net_data);
      hold_pend = net_valid && !net_ready;
      hold_d    = net_data;
      mem_rvalid = 1'b0;
      if (pend.size() > 0 && $urandom_range(99) < rv_pct) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(pend.pop_front());
      end
      mem_req_ready = ($urandom_range(99) < mem_pct);
      if (mem_req && mem_req_ready) begin
        pend.push_back(mem_addr);
        rd_cnt++;
      end
      if (pend.size() > DEPTH) cap_bad++;
    end
  end

  task automatic write_cmd(logic [31:0] dest, logic [31:0] addr,
                           logic [31:0] size, logic [31:0] tag);
    logic [31:0] w [4];
    w[0] = dest; w[1] = addr; w[2] = size; w[3] = tag;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_data = w[i];
    end
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(busy == 1'b1, "R8", "busy after fourth word", busy, 1);
  endtask

  task automatic finish_send(logic [31:0] dest, logic [31:0] addr,
                             logic [31:0] size, logic [31:0] tag, int base);
    int bad = 0;
    int first = -1;
    while (done_cnt == base) @(negedge clk);
    chk(rxq.size() == size + 2, "R3", "word count", rxq.size(), size + 2);
    if (rxq.size() >= 2) begin
      chk(rxq[0] == {dest[15:0], tag[15:0]}, "R1", "header word 0", rxq[0], {dest[15:0], tag[15:0]});
      chk(rxq[1] == size, "R2", "header word 1", rxq[1], size);
    end
    for (int k = 0; k < int'(size) && k + 2 < rxq.size(); k++)
      if (rxq[k+2] != mem_word(addr + 32'(k*4))) begin
        bad++;
        if (first < 0) first = k;
      end
    if (first >= 0)
      chk(0, "R3", "payload word", rxq[first+2], mem_word(addr + 32'(first*4)));
    else
      chk(1, "R3", "payload", 0, 0);
    chk(rd_cnt == int'(size), "R10", "reads accepted", rd_cnt, size);
    if (size == 0) chk(rd_cnt == 0, "R4", "no reads on empty send", rd_cnt, 0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
    chk(done_busy_bad == 0 && done_wide == 0, "R7", "done pulse shape", done_busy_bad + done_wide, 0);
    chk(hold_bad == 0, "R9", "stall hold violations", hold_bad, 0);
    chk(cap_bad == 0, "R5", "outstanding above limit", cap_bad, 0);
  endtask

  task automatic run_send(logic [31:0] dest, logic [31:0] addr,
                          logic [31:0] size, logic [31:0] tag);
    int base;
    rxq.delete();
    rd_cnt = 0;
    base = done_cnt;
    write_cmd(dest, addr, size, tag);
    finish_send(dest, addr, size, tag, base);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R8", "reset busy", busy, 0);
    chk(done == 0, "R8", "reset done", done, 0);
    chk(cmd_err == 0, "R8", "reset err", cmd_err, 0);
    chk(net_valid == 0, "R8", "reset net_valid", net_valid, 0);
    chk(mem_req == 0, "R8", "reset mem_req", mem_req, 0);

    // R4: header-only message
    run_send(32'h0000_0007, 32'h1000, 0, 32'h0000_00AB);
    // single word
    run_send(32'h0000_1234, 32'h2000, 1, 32'h0000_BEEF);

    // R5: network stalled, memory fast -> buffer fills to the limit
    begin
      int base;
      rxq.delete(); rd_cnt = 0; base = done_cnt;
      net_pct = 0; mem_pct = 100; rv_pct = 100;
      write_cmd(32'h0000_0003, 32'h3000, 12, 32'h0000_0055);
      repeat (40) @(negedge clk);
      chk(pend.size() == 0 && rd_cnt == DEPTH, "R5", "reads held at buffer limit", rd_cnt, DEPTH);
      net_pct = 100;
      finish_send(32'h0000_0003, 32'h3000, 12, 32'h0000_0055, base);
    end

    // R6: write while busy is ignored and flagged
    begin
      int base;
      rxq.delete(); rd_cnt = 0; base = done_cnt;
      net_pct = 40; mem_pct = 60; rv_pct = 60;
      write_cmd(32'h0000_0011, 32'h4000, 16, 32'h0000_0022);
      chk(cmd_err == 0, "R6", "flag clear before", cmd_err, 0);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_data = 32'hDEAD_DEAD;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(cmd_err == 1, "R6", "flag set on busy write", cmd_err, 1);
      finish_send(32'h0000_0011, 32'h4000, 16, 32'h0000_0022, base);
      run_send(32'h0000_0ACE, 32'h5000, 3, 32'h0000_0F0F);
      chk(cmd_err == 1, "R6", "flag sticky", cmd_err, 1);
    end

    // memory slow, network fast
    net_pct = 100; mem_pct = 30; rv_pct = 25;
    run_send(32'hFFFF_FFFF, 32'hFFFF_FFF0, 5, 32'hFFFF_0001);

    for (int n = 0; n < 20; n++) begin
      net_pct = 30 + $urandom_range(70);
      mem_pct = 30 + $urandom_range(70);
      rv_pct  = 30 + $urandom_range(70);
      run_send($urandom, {$urandom_range(32'h0FFF_FFFF), 2'b00}, $urandom_range(20), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule